// File: doc/BRIEF.md
# Gated Ripple-Carry Bit-Slice ALU

This block is a combinational arithmetic logic unit of parameterised width, eight bits by default. It is built from identical one-bit slices placed side by side. Each slice takes one bit of each operand and applies three controls to them. A per-operand enable either passes the bit or forces it to zero. An inversion control then complements the gated A bit. A two-bit function code selects AND, OR, complement of B, or full-adder sum. The carry of the sum passes from each slice to the next higher one.

The carry into bit 0 comes from an increment control. So the same adder path yields A+B, A+B+1, A+1, -A, B-A and a constant of all ones, depending only on how the enables, the inversion and the increment are set. Results appear on the outputs without any clock. The carry out of the top slice is the final carry output.

Top module: `bitslice_alu`

## Requirements
- R1: When `en_a` is 0, operand A enters every slice as 0; for example, OR with `en_a`=0 and `inv_a`=0 returns B.
- R2: When `en_b` is 0, operand B enters every slice as 0; for example, an add with `en_b`=0, `inv_a`=0 and `inc`=0 returns A.
- R3: `inv_a` complements A after gating, so `en_a`=0 with `inv_a`=1 presents A as all ones.
- R4: Function code 2'b00 gives `result` = gated A AND gated B, with `carry_out` = 0.
- R5: Function code 2'b01 gives `result` = gated A OR gated B, with `carry_out` = 0.
- R6: Function code 2'b10 gives `result` = NOT of gated B, with `carry_out` = 0; A, `inv_a` and `en_a` have no effect.
- R7: Function code 2'b11 gives {`carry_out`, `result`} = gated A + gated B + `inc`, taken to WIDTH+1 bits.
- R8: In the three logic functions `inc` has no effect: `carry_out` stays 0 and `result` is unchanged.
- R9: With `en_a`=1, `en_b`=0, `inv_a`=1, `inc`=1 and code 2'b11, `result` is the two's-complement negation of A, and `carry_out` is 1 exactly when A is 0.
- R10: With `en_a`=1, `en_b`=1, `inv_a`=1, `inc`=1 and code 2'b11, `result` is B-A modulo 2^WIDTH, and `carry_out` is 1 exactly when B >= A.
- R11: The carry ripples across the full width; for example, 8'hFF + 8'h01 gives `result` 0 with `carry_out` 1.
- R12: The block holds no state: the outputs follow a change of the inputs with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | Operand A |
| opnd_b | input | WIDTH | Operand B |
| en_a | input | 1 | Passes A when 1, forces A to zero when 0 |
| en_b | input | 1 | Passes B when 1, forces B to zero when 0 |
| inv_a | input | 1 | Complements gated A when 1 |
| inc | input | 1 | Carry into the least significant slice |
| func | input | 2 | Function code: 00 AND, 01 OR, 10 NOT B, 11 add |
| result | output | WIDTH | Result of the selected function |
| carry_out | output | 1 | Carry out of the top slice (0 in logic functions) |

## Verification
Gating, inversion and the increment carry all act in the same evaluation as the add. The riskiest overlap is the negation and subtraction setting, where `inv_a` and `inc` must both reach the sum together. The bench sets all controls at once for the -A and B-A cases. It sweeps every value of A for negation and compares each result and carry against a reference written from R7, R9 and R10. It also drives `inc`=1 into every logic code and checks that the carry stays 0 and the result matches the same code with `inc`=0.

// File: rtl/bitslice_alu_pkg.sv
// Package: shared types for the bit-slice ALU.
// Assumes: function code is two bits, encoding fixed by the requirements.
package bitslice_alu_pkg;

    // Function selected in every slice.
    typedef enum logic [1:0] {
        FN_AND  = 2'b00,
        FN_OR   = 2'b01,
        FN_NOTB = 2'b10,
        FN_ADD  = 2'b11
    } alu_fn_e;

    localparam int FN_W = 2;

endpackage

// File: rtl/alu_operand_gate.sv
// Module: alu_operand_gate
// Gates both operand bits with their enables and optionally inverts the
// gated A bit. Assumes inversion is applied strictly after gating.
module alu_operand_gate (
    input  logic a_in,
    input  logic b_in,
    input  logic en_a,
    input  logic en_b,
    input  logic inv_a,
    output logic a_eff,
    output logic b_eff
);

    logic a_gated;

    // Force disabled operands to zero, then apply the A inversion.
    always_comb begin
        a_gated = a_in & en_a;
        a_eff   = a_gated ^ inv_a;
        b_eff   = b_in & en_b;
    end

endmodule

// File: rtl/alu_full_adder.sv
// Module: alu_full_adder
// One-bit full adder. Assumes inputs are already gated and inverted.
module alu_full_adder (
    input  logic x,
    input  logic y,
    input  logic cin,
    output logic sum,
    output logic cout
);

    logic half;

    // Sum and majority carry.
    always_comb begin
        half = x ^ y;
        sum  = half ^ cin;
        cout = (x & y) | (half & cin);
    end

endmodule

// File: rtl/alu_bit_slice.sv
// Module: alu_bit_slice
// One bit of the ALU: operand gating, logic section and adder, with a
// function select choosing the bit result. Assumes the logic functions
// never propagate a carry, so their carry out is 0.
module alu_bit_slice
    import bitslice_alu_pkg::*;
(
    input  logic    a_in,
    input  logic    b_in,
    input  logic    en_a,
    input  logic    en_b,
    input  logic    inv_a,
    input  alu_fn_e fn,
    input  logic    cin,
    output logic    y,
    output logic    cout
);

    logic a_eff;
    logic b_eff;
    logic add_sum;
    logic add_cout;

    alu_operand_gate gate_i (
        .a_in  (a_in),
        .b_in  (b_in),
        .en_a  (en_a),
        .en_b  (en_b),
        .inv_a (inv_a),
        .a_eff (a_eff),
        .b_eff (b_eff)
    );

    alu_full_adder fa_i (
        .x    (a_eff),
        .y    (b_eff),
        .cin  (cin),
        .sum  (add_sum),
        .cout (add_cout)
    );

    // Choose the bit result and the carry passed upward.
    always_comb begin
        cout = 1'b0;
        unique case (fn)
            FN_AND:  y = a_eff & b_eff;
            FN_OR:   y = a_eff | b_eff;
            FN_NOTB: y = ~b_eff;
            FN_ADD: begin
                y    = add_sum;
                cout = add_cout;
            end
            default: y = 1'b0;
        endcase
    end

endmodule

// File: rtl/bitslice_alu.sv
// Module: bitslice_alu (top)
// WIDTH identical slices chained by a ripple carry; inc feeds bit 0 and the
// top slice's carry is the carry output. Purely combinational, no reset.
module bitslice_alu
    import bitslice_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic             en_a,
    input  logic             en_b,
    input  logic             inv_a,
    input  logic             inc,
    input  logic [FN_W-1:0]  func,
    output logic [WIDTH-1:0] result,
    output logic             carry_out
);

    localparam int CHAIN_W = WIDTH + 1;

    logic [CHAIN_W-1:0] carry;
    alu_fn_e            fn_sel;

    // Decode the function code and seed the carry chain.
    always_comb begin
        fn_sel   = alu_fn_e'(func);
        carry[0] = inc;
    end

    genvar gi;
    generate
        for (gi = 0; gi < WIDTH; gi++) begin : g_slice
            alu_bit_slice slice_i (
                .a_in  (opnd_a[gi]),
                .b_in  (opnd_b[gi]),
                .en_a  (en_a),
                .en_b  (en_b),
                .inv_a (inv_a),
                .fn    (fn_sel),
                .cin   (carry[gi]),
                .y     (result[gi]),
                .cout  (carry[gi+1])
            );
        end
    endgenerate

    // Final carry comes from the top slice.
    always_comb carry_out = carry[WIDTH];

endmodule

// File: rtl/bitslice_alu_checker.sv
// Module: bitslice_alu_checker
// Immediate assertions on the ALU ports; the block has no clock, so each
// check is evaluated whenever the ports change.
module bitslice_alu_checker #(
    parameter int WIDTH = 8
) (
    input logic [WIDTH-1:0] opnd_a,
    input logic [WIDTH-1:0] opnd_b,
    input logic             en_a,
    input logic             en_b,
    input logic             inv_a,
    input logic             inc,
    input logic [1:0]       func,
    input logic [WIDTH-1:0] result,
    input logic             carry_out
);

    logic [WIDTH-1:0] ga;
    logic [WIDTH-1:0] gb;
    logic [WIDTH:0]   ref_sum;

    // Independent operand model and port checks.
    always_comb begin
        ga      = (en_a ? opnd_a : '0) ^ {WIDTH{inv_a}};
        gb      = en_b ? opnd_b : '0;
        ref_sum = {1'b0, ga} + {1'b0, gb} + {{WIDTH{1'b0}}, inc};
        if (func == 2'b00) assert_and_R4: assert (result == (ga & gb));
        if (func == 2'b01) assert_or_R5: assert (result == (ga | gb));
        if (func == 2'b10) assert_notb_R6: assert (result == ~gb);
        if (func == 2'b11) assert_add_R7: assert ({carry_out, result} == ref_sum);
        if (func != 2'b11) assert_no_logic_carry_R8: assert (carry_out == 1'b0);
        if (func == 2'b01 && !en_a && !inv_a) assert_gate_a_R1: assert (result == gb);
        if (func == 2'b11 && en_a && !en_b && inv_a && inc)
            assert_negate_R9: assert (result == (~opnd_a + 1'b1));
    end

endmodule

bind bitslice_alu bitslice_alu_checker #(.WIDTH(WIDTH)) chk_i (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .en_a      (en_a),
    .en_b      (en_b),
    .inv_a     (inv_a),
    .inc       (inc),
    .func      (func),
    .result    (result),
    .carry_out (carry_out)
);

// File: tb/bitslice_alu_tb.sv
// Bench: vector table, then directed sweeps for negation, subtraction,
// logic-mode increment and clockless response.
module bitslice_alu_tb_top;

    localparam int W      = 8;
    localparam int NVEC   = 16;
    localparam int VEC_W  = 35;
    localparam int MAXCYC = 200000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a, b;
    logic         ena, enb, inva, inc;
    logic [1:0]   fn;
    logic [W-1:0] res;
    logic         cout;
    int           n_run = 0;
    int           n_fail = 0;
    bit           done = 1'b0;

    always #10 clk = ~clk;

    bitslice_alu #(.WIDTH(W)) dut_i (
        .opnd_a    (a),
        .opnd_b    (b),
        .en_a      (ena),
        .en_b      (enb),
        .inv_a     (inva),
        .inc       (inc),
        .func      (fn),
        .result    (res),
        .carry_out (cout)
    );

    // {ena,enb,inva,inc,fn,a,b,exp_res,exp_cout,req}
    localparam logic [VEC_W-1:0] VEC [NVEC] = '{
        {4'b1100, 2'd0, 8'hC3, 8'hA5, 8'h81, 1'b0, 4'd4},   // R4
        {4'b1100, 2'd1, 8'hC3, 8'hA5, 8'hE7, 1'b0, 4'd5},   // R5
        {4'b1111, 2'd2, 8'hFF, 8'h0F, 8'hF0, 1'b0, 4'd6},   // R6
        {4'b1100, 2'd3, 8'h3C, 8'h55, 8'h91, 1'b0, 4'd7},   // R7
        {4'b1101, 2'd3, 8'h80, 8'h7F, 8'h00, 1'b1, 4'd7},   // R7
        {4'b1100, 2'd3, 8'hFF, 8'h01, 8'h00, 1'b1, 4'd11},  // R11
        {4'b0100, 2'd1, 8'hFF, 8'h12, 8'h12, 1'b0, 4'd1},   // R1
        {4'b1000, 2'd3, 8'h5A, 8'hFF, 8'h5A, 1'b0, 4'd2},   // R2
        {4'b0110, 2'd0, 8'h00, 8'h6B, 8'h6B, 1'b0, 4'd3},   // R3
        {4'b1011, 2'd3, 8'h05, 8'hAA, 8'hFB, 1'b0, 4'd9},   // R9
        {4'b1111, 2'd3, 8'h30, 8'h50, 8'h20, 1'b1, 4'd10},  // R10
        {4'b1111, 2'd3, 8'h50, 8'h30, 8'hE0, 1'b0, 4'd10},  // R10
        {4'b1101, 2'd0, 8'hFF, 8'hFF, 8'hFF, 1'b0, 4'd8},   // R8
        {4'b1110, 2'd1, 8'hF0, 8'h00, 8'h0F, 1'b0, 4'd3},   // R3
        {4'b1011, 2'd3, 8'h00, 8'h00, 8'h00, 1'b1, 4'd9},   // R9
        {4'b1000, 2'd2, 8'hAA, 8'h55, 8'hFF, 1'b0, 4'd6}    // R6
    };

    task automatic check(input int req, input logic [W-1:0] got_r,
                         input logic [W-1:0] exp_r, input logic got_c,
                         input logic exp_c);
        n_run++;
        if (got_r !== exp_r || got_c !== exp_c) begin
            n_fail++;
            $display("FAIL R%0d: result=%h carry=%b expected result=%h carry=%b",
                     req, got_r, got_c, exp_r, exp_c);
        end
    endtask

    task automatic drive(input logic [3:0] ctl, input logic [1:0] f,
                         input logic [W-1:0] va, input logic [W-1:0] vb);
        @(negedge clk);
        {ena, enb, inva, inc} = ctl;
        fn = f;
        a  = va;
        b  = vb;
        #2;
    endtask

    // Reference add path built from R7.
    function automatic logic [W:0] ref_add(input logic [3:0] ctl,
                                           input logic [W-1:0] va,
                                           input logic [W-1:0] vb);
        logic [W-1:0] xa, xb;
        xa = (ctl[3] ? va : '0) ^ {W{ctl[1]}};
        xb = ctl[2] ? vb : '0;
        return {1'b0, xa} + {1'b0, xb} + {{W{1'b0}}, ctl[0]};
    endfunction

    initial begin
        logic [W:0]   e;
        logic [W-1:0] r0;
        {ena, enb, inva, inc} = 4'b0000;
        fn = 2'b00;
        a  = '0;
        b  = '0;
        repeat (3) @(posedge clk);
        #5;
        check(4, res, 8'h00, cout, 1'b0);   // reset state, R4 with zero inputs
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i][34:31], VEC[i][30:29], VEC[i][28:21], VEC[i][20:13]);
            check(int'(VEC[i][3:0]), res, VEC[i][12:5], cout, VEC[i][4]);
        end

        // R9: negation for every A value.
        for (int v = 0; v < 256; v++) begin
            drive(4'b1011, 2'd3, W'(v), 8'h5C);
            check(9, res, W'(256 - v), cout, v == 0);
        end

        // R10: B-A across a spread of pairs.
        for (int v = 0; v < 64; v++) begin
            logic [W-1:0] va, vb;
            va = W'(v * 37 + 11);
            vb = W'(v * 91 + 3);
            drive(4'b1111, 2'd3, va, vb);
            check(10, res, vb - va, cout, vb >= va);
        end

        // R7 and R2: add with every control mix.
        for (int c = 0; c < 16; c++) begin
            drive(4'(c), 2'd3, 8'hB7, 8'h6D);
            e = ref_add(4'(c), 8'hB7, 8'h6D);
            check(7, res, e[W-1:0], cout, e[W]);
        end

        // R8: inc has no effect in each logic code.
        for (int f = 0; f < 3; f++) begin
            drive(4'b1100, 2'(f), 8'h9C, 8'h3A);
            r0 = res;
            drive(4'b1101, 2'(f), 8'h9C, 8'h3A);
            check(8, res, r0, cout, 1'b0);
        end

        // R6: A side has no effect on NOT B.
        drive(4'b0000, 2'd2, 8'h00, 8'hC5);
        drive(4'b1110, 2'd2, 8'h77, 8'hC5);
        check(6, res, 8'h3A, cout, 1'b0);

        // R12: output follows inputs between clock edges.
        @(posedge clk);
        #3;
        {ena, enb, inva, inc} = 4'b1100;
        fn = 2'd3;
        a  = 8'h10;
        b  = 8'h20;
        #1;
        check(12, res, 8'h30, cout, 1'b0);
        b = 8'hF0;
        #1;
        check(12, res, 8'h00, cout, 1'b1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (MAXCYC) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule